// File: doc/BRIEF.md
# Bank-Switched Upper Memory Controller

This block sits beside a CPU's 64 KB address decoder and decides what the CPU sees in the top 12 KB of the map (D000 to FFFF). A 16-address control window takes any access, read or write. The low address bits of that access are stored as a small mode value. The mode value chooses three things: whether reads of the upper region come from ROM or from RAM, whether RAM in that region may be written, and which of two RAM banks answers in the 4 KB D000-DFFF window. The RAM and ROM arrays are outside the block. The block drives their selects, a RAM write enable, an auxiliary-RAM select and the physical RAM address.

The mode register is the only state. Every select and status output is combinational from the current access and the stored mode, so a mode change made by one access applies to the next access. A separate alternate-RAM input moves all RAM traffic in the region from main RAM to auxiliary RAM. It acts immediately and does not touch the stored mode.

Top module: `upmem_ctrl`

## Requirements
- R1: A valid access (read or write) to any of the 16 addresses C080-C08F loads the mode register with address bits [3:0] ANDed with 4'b1011 at the next clock edge, so bit 2 of the stored mode is always 0.
- R2: Synchronous reset sets the mode to 4'h2: reads of the upper region come from ROM and writes are disabled.
- R3: A valid read at an address of D000 or above asserts rom_rd when mode bit 0 XOR mode bit 1 is 1, and asserts ram_rd otherwise. The two are never asserted together.
- R4: A valid write at an address of D000 or above asserts ram_we only when mode bit 0 is 1. Otherwise the write is dropped, whether reads currently come from ROM or from RAM.
- R5: With mode bit 3 set, addresses D000-DFFF map to ram_addr C000-CFFF (the address minus 16'h1000). With bit 3 clear, ram_addr equals the CPU address. E000-FFFF always maps to itself.
- R6: When alt_ram is 1, ram_aux is asserted for every RAM read or write that the block enables. A change of alt_ram applies to the same access and leaves mode_q unchanged.
- R7: bank_stat is 8'h80 when mode bit 3 is 0 and 8'h00 otherwise.
- R8: ram_stat is 8'h80 when upper-region reads come from RAM (bit 0 XNOR bit 1) and 8'h00 otherwise.
- R9: win_hit is 1 for a valid access to C080-C08F, and win_rdata is 8'h00 at all times.
- R10: Accesses outside the control window, and cycles without cpu_valid, leave the mode unchanged. Accesses below D000 assert none of rom_rd, ram_rd, ram_we or ram_aux.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_valid | input | 1 | Access strobe for this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| alt_ram | input | 1 | Route region RAM traffic to auxiliary RAM |
| rom_rd | output | 1 | Read served from ROM |
| ram_rd | output | 1 | Read served from RAM |
| ram_we | output | 1 | RAM write enable |
| ram_aux | output | 1 | RAM access goes to auxiliary RAM |
| ram_addr | output | 16 | Physical RAM address after bank remap |
| win_hit | output | 1 | Access hits the control window |
| win_rdata | output | 8 | Read data for control-window reads |
| bank_stat | output | 8 | Bank status byte |
| ram_stat | output | 8 | RAM-read status byte |
| mode_q | output | 4 | Stored mode value |

## Verification
Every one of the sixteen window addresses is used to load the mode, with reads and writes. A design that kept bit 2, or that ignored window reads, would show the wrong mode_q and wrong status bytes. Each mode is then crossed with addresses at the edges of the banked window (CFFF, D000, DFFF, E000, FFFF), both directions and both alt_ram values. This finds a ROM/RAM select that uses the wrong bit combination, a write enable that follows the read source instead of bit 0, a bank remap that spills into E000, and auxiliary routing that also fires on ROM reads. After each sweep the bench checks that mode_q has not moved, which catches a decoder that loads on non-window accesses or on alt_ram changes.

// File: rtl/upmem_pkg.sv
package upmem_pkg;

    localparam int ADDR_W = 16;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_MASK  = 4'b1011;
    localparam logic [MODE_W-1:0] MODE_RESET = 4'h2;

    typedef logic [MODE_W-1:0] mode_t;

    typedef struct packed {
        logic              rom_rd;
        logic              ram_rd;
        logic              ram_we;
        logic              ram_aux;
        logic [ADDR_W-1:0] ram_addr;
    } route_t;

    function automatic logic mode_reads_rom(mode_t m);
        return m[0] ^ m[1];
    endfunction

    function automatic logic mode_writes_ok(mode_t m);
        return m[0];
    endfunction

    function automatic logic mode_bank1(mode_t m);
        return m[3];
    endfunction

    function automatic logic [7:0] flag_byte(logic f);
        return {f, 7'b0};
    endfunction

endpackage

// File: rtl/upmem_win_dec.sv
module upmem_win_dec
    import upmem_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTL_BASE = 16'hC080
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    output logic              hit,
    output mode_t             next_mode
);
    localparam int WIN_LSB = MODE_W;

    always_comb begin
        hit       = valid && (addr[ADDR_W-1:WIN_LSB] == CTL_BASE[ADDR_W-1:WIN_LSB]);
        next_mode = addr[MODE_W-1:0] & MODE_MASK;
    end
endmodule

// File: rtl/upmem_mode_reg.sv
module upmem_mode_reg
    import upmem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  mode_t d,
    output mode_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= MODE_RESET;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/upmem_map.sv
module upmem_map
    import upmem_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REGION_BASE = 16'hD000,
    parameter logic [ADDR_W-1:0] BANKED_TOP  = 16'hE000,
    parameter logic [ADDR_W-1:0] BANK1_BASE  = 16'hC000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    input  logic              wr,
    input  logic              alt,
    input  mode_t             mode,
    output route_t            route
);
    localparam logic [ADDR_W-1:0] BANK_SHIFT = REGION_BASE - BANK1_BASE;

    logic in_region;
    logic in_banked;
    logic rd_rom;

    always_comb begin
        in_region = valid && (addr >= REGION_BASE);
        in_banked = (addr >= REGION_BASE) && (addr < BANKED_TOP);
        rd_rom    = mode_reads_rom(mode);

        route.rom_rd  = in_region && !wr && rd_rom;
        route.ram_rd  = in_region && !wr && !rd_rom;
        route.ram_we  = in_region && wr && mode_writes_ok(mode);
        route.ram_aux = alt && (route.ram_rd || route.ram_we);
        route.ram_addr = (in_banked && mode_bank1(mode)) ? (addr - BANK_SHIFT) : addr;
    end
endmodule

// File: rtl/upmem_ctrl.sv
module upmem_ctrl
    import upmem_pkg::*;
#(
    parameter logic [15:0] CTL_BASE    = 16'hC080,
    parameter logic [15:0] REGION_BASE = 16'hD000,
    parameter logic [15:0] BANKED_TOP  = 16'hE000,
    parameter logic [15:0] BANK1_BASE  = 16'hC000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_valid,
    input  logic        cpu_wr,
    input  logic        alt_ram,
    output logic        rom_rd,
    output logic        ram_rd,
    output logic        ram_we,
    output logic        ram_aux,
    output logic [15:0] ram_addr,
    output logic        win_hit,
    output logic [7:0]  win_rdata,
    output logic [7:0]  bank_stat,
    output logic [7:0]  ram_stat,
    output logic [3:0]  mode_q
);
    mode_t  next_mode;
    mode_t  mode;
    route_t route;

    upmem_win_dec #(.CTL_BASE(CTL_BASE)) u_dec (
        .addr      (cpu_addr),
        .valid     (cpu_valid),
        .hit       (win_hit),
        .next_mode (next_mode)
    );

    upmem_mode_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (win_hit),
        .d    (next_mode),
        .q    (mode)
    );

    upmem_map #(
        .REGION_BASE (REGION_BASE),
        .BANKED_TOP  (BANKED_TOP),
        .BANK1_BASE  (BANK1_BASE)
    ) u_map (
        .addr  (cpu_addr),
        .valid (cpu_valid),
        .wr    (cpu_wr),
        .alt   (alt_ram),
        .mode  (mode),
        .route (route)
    );

    always_comb begin
        rom_rd    = route.rom_rd;
        ram_rd    = route.ram_rd;
        ram_we    = route.ram_we;
        ram_aux   = route.ram_aux;
        ram_addr  = route.ram_addr;
        win_rdata = 8'h00;
        bank_stat = flag_byte(!mode_bank1(mode));
        ram_stat  = flag_byte(!mode_reads_rom(mode));
        mode_q    = mode;
    end
endmodule

// File: rtl/upmem_chk.sv
module upmem_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic        cpu_valid,
    input logic        cpu_wr,
    input logic        rom_rd,
    input logic        ram_rd,
    input logic        ram_we,
    input logic        ram_aux,
    input logic [15:0] ram_addr,
    input logic        win_hit,
    input logic [7:0]  win_rdata,
    input logic [3:0]  mode_q
);
    AST_WIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        win_hit |=> mode_q == ($past(cpu_addr[3:0]) & 4'b1011)); // R1
    AST_RESET_MODE: assert property (@(posedge clk)
        rst |=> mode_q == 4'h2); // R2
    AST_SRC_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rom_rd && ram_rd)); // R3
    AST_WE_NEEDS_BIT0: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (mode_q[0] && cpu_wr)); // R4
    AST_TOP_NO_REMAP: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr >= 16'hE000) |-> ram_addr == cpu_addr); // R5
    AST_AUX_ONLY_RAM: assert property (@(posedge clk) disable iff (rst)
        ram_aux |-> (ram_rd || ram_we)); // R6
    AST_WIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> win_rdata == 8'h00); // R9
    AST_HOLD_MODE: assert property (@(posedge clk) disable iff (rst)
        !win_hit |=> $stable(mode_q)); // R10
    AST_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_addr < 16'hD000) |-> !(rom_rd || ram_rd || ram_we)); // R10
endmodule

bind upmem_ctrl upmem_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_valid (cpu_valid),
    .cpu_wr    (cpu_wr),
    .rom_rd    (rom_rd),
    .ram_rd    (ram_rd),
    .ram_we    (ram_we),
    .ram_aux   (ram_aux),
    .ram_addr  (ram_addr),
    .win_hit   (win_hit),
    .win_rdata (win_rdata),
    .mode_q    (mode_q)
);

// File: tb/upmem_ctrl_tb.sv
module upmem_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        cpu_valid;
    logic        cpu_wr;
    logic        alt_ram;
    logic        rom_rd, ram_rd, ram_we, ram_aux, win_hit;
    logic [15:0] ram_addr;
    logic [7:0]  win_rdata, bank_stat, ram_stat;
    logic [3:0]  mode_q;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    upmem_ctrl dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_valid(cpu_valid),
        .cpu_wr(cpu_wr), .alt_ram(alt_ram), .rom_rd(rom_rd), .ram_rd(ram_rd),
        .ram_we(ram_we), .ram_aux(ram_aux), .ram_addr(ram_addr),
        .win_hit(win_hit), .win_rdata(win_rdata), .bank_stat(bank_stat),
        .ram_stat(ram_stat), .mode_q(mode_q)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] model(logic [3:0] m, logic [15:0] a, logic w, logic alt);
        logic reg_ok, rrom, rram, we, aux;
        logic [15:0] pa;
        reg_ok = a >= 16'hD000;
        rrom = reg_ok && !w && (m[0] != m[1]);
        rram = reg_ok && !w && (m[0] == m[1]);
        we   = reg_ok && w && m[0];
        aux  = alt && (rram || we);
        pa   = (m[3] && a >= 16'hD000 && a < 16'hE000) ? a - 16'h1000 : a;
        return {rrom, rram, we, aux, pa};
    endfunction

    logic [15:0] probe [8] = '{16'h0000, 16'hC08F, 16'hCFFF, 16'hD000,
                               16'hD5A3, 16'hDFFF, 16'hE000, 16'hFFFF};

    initial begin
        rst = 1'b1; cpu_addr = '0; cpu_valid = 0; cpu_wr = 0; alt_ram = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R2 reset mode", mode_q, 4'h2);
        chk("R2 reset status", {bank_stat, ram_stat}, {8'h80, 8'h00});
        // idle window address without valid: R10
        cpu_addr = 16'hC08B;
        @(negedge clk); #1;
        chk("R10 no valid no load", mode_q, 4'h2);
        for (int s = 0; s < 16; s++) begin
            logic [3:0] em;
            em = 4'(s) & 4'b1011;
            cpu_addr = 16'hC080 + 16'(s); cpu_valid = 1; cpu_wr = s[0] ^ s[2];
            #1;
            chk("R9 win hit", {win_hit, win_rdata}, {1'b1, 8'h00});
            @(negedge clk);
            cpu_valid = 0; #1;
            chk("R1 mode load", mode_q, em);
            chk("R7 bank stat", bank_stat, em[3] ? 8'h00 : 8'h80);
            chk("R8 ram stat", ram_stat, (em[0] ^ em[1]) ? 8'h00 : 8'h80);
            for (int p = 0; p < 8; p++) begin
                for (int k = 0; k < 4; k++) begin
                    cpu_addr = probe[p]; cpu_valid = (p != 1); cpu_wr = k[0]; alt_ram = k[1];
                    #1;
                    if (p != 1)
                        chk("R3 R4 R5 R6 route", {rom_rd, ram_rd, ram_we, ram_aux, ram_addr},
                            model(em, probe[p], k[0], k[1]));
                    @(negedge clk);
                end
            end
            cpu_valid = 0; alt_ram = 0; #1;
            chk("R6 R10 mode held", mode_q, em);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog act=hang exp=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule